// File: doc/BRIEF.md
# Flash Address, Erase and Row-Program Controller

This block sits between a CPU register bus and an on-chip flash array. Software loads a three-part flash address (page, row, column) through three registers and then streams bytes through a data-port register. Every accepted data-port access moves the address forward by one byte. Column overflow carries into the row, and row overflow carries into the page. A separate read path lets the CPU fetch flash bytes directly by flat address.

A control register starts one of three operations: a mass erase of the whole main array, a page erase of one page, or a row-program window. The mass erase also covers the information page if the information-page enable bit in the page register was set when the command was issued. The erase durations are cycle counts derived from a clock-rate parameter in kHz and from millisecond parameters. The command bits clear themselves when the operation ends.

During an operation, the block raises a combinational stall output for flash accesses that must wait. The master holds its strobe while stall is high. Accesses that do not target flash never stall. The cell array is a behavioural model. An erase writes 0xFF into the affected pages on the final cycle of the erase. Programming clears bits, so the stored byte becomes old AND new.

Top module: `flash_io_ctrl`

## Requirements
- R1: After reset, the column (select 0), row (select 1), page (select 2) and control (select 4) registers read 0x00, and stall is low.
- R2: The column register is 8 bits read/write. The row register keeps its ROW_W low bits. The page register keeps its PAGE_W low bits plus bit 7 (information-page enable). All other bits read 0.
- R3: Each data-port (select 3) read or write that is not stalled advances the {page,row,column} address by one. Column 255 wraps to 0 with a carry into the row, and the last row wraps with a carry into the page. The page field wraps to 0, and bit 7 is unchanged.
- R4: A data-port read returns the byte at the address held before the increment. A CPU read returns the byte at cpu_addr = {page,row,column} in the main array.
- R5: While the program bit (control bit 2) is set, a data-port write stores old AND new at the current address. Without it, a data-port write leaves the array unchanged but still advances the address.
- R6: Writing control bit 1 starts a page erase of the selected page. Control reads 0x82 for exactly PAGE_MS*CLK_KHZ cycles and then reads 0x00. The page then reads 0xFF, and other pages keep their contents.
- R7: Writing control bit 0 starts a mass erase. Control reads 0x81 for exactly MASS_MS*CLK_KHZ cycles. Afterwards every main byte reads 0xFF. The information page is cleared only if page bit 7 was set at the command, and the duration does not depend on it.
- R8: During an erase, a CPU flash access or a data-port access raises stall and has no effect on the address. A CPU access with cpu_is_flash low never stalls.
- R9: During programming, CPU flash reads and data-port reads raise stall, and data-port writes do not.
- R10: Programming ends when software writes the control register with bit 2 at 0, or after PROG_TMO cycles without an accepted data-port write. Control then reads 0x00.
- R11: A command written while an erase is running is ignored. Control bit 7 reads 1 whenever an operation is running.
- R12: If several command bits are written together while idle, mass erase wins over page erase, which wins over program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select: 0 column, 1 row, 2 page, 3 data port, 4 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_req | input | 1 | CPU memory access strobe |
| cpu_is_flash | input | 1 | Access targets the flash range |
| cpu_we | input | 1 | Access is a write (no effect on the array) |
| cpu_addr | input | PAGE_W+ROW_W+8 | Flat main-array byte address |
| cpu_rdata | output | 8 | Flash read data (combinational) |
| stall | output | 1 | Access must be held: wait state |

## Verification
A wrong address counter shows up on the very next data-port read: that read returns the wrong byte, and the column, row and page registers read back the wrong values. A wrong erase timer shows up as control bit 7 falling one or more cycles early or late, which the bench measures to the cycle. An erase applied to the wrong pages is caught when CPU reads of untouched pages do not return the bytes the bench programmed there. A missing stall term shows up in the same cycle as the access, and a stalled access that is wrongly accepted shows up as a moved address.

// File: rtl/flash_io_pkg.sv
package flash_io_pkg;

   typedef enum logic [2:0] {
      SEL_COL  = 3'd0,
      SEL_ROW  = 3'd1,
      SEL_PAGE = 3'd2,
      SEL_DATA = 3'd3,
      SEL_CTRL = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_MASS = 2'd1,
      OP_PAGE = 2'd2,
      OP_PROG = 2'd3
   } op_e;

   localparam int CMD_MASS = 0;
   localparam int CMD_PAGE = 1;
   localparam int CMD_PROG = 2;
   localparam int CTL_BUSY = 7;
   localparam int PG_INFO  = 7;

endpackage

// File: rtl/flash_io_addr.sv
module flash_io_addr #(
   parameter int ROW_W  = 1,
   parameter int PAGE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              col_wr,
   input  logic              row_wr,
   input  logic              page_wr,
   input  logic [7:0]        col_in,
   input  logic [ROW_W-1:0]  row_in,
   input  logic [PAGE_W-1:0] page_in,
   input  logic              info_in,
   input  logic              step,
   output logic [7:0]        col,
   output logic [ROW_W-1:0]  row,
   output logic [PAGE_W-1:0] page,
   output logic              info_en
);
   localparam int FW = PAGE_W + ROW_W + 8;

   logic [FW-1:0] flat, flat_nx;

   assign flat    = {page, row, col};
   assign flat_nx = flat + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col     <= '0;
         row     <= '0;
         page    <= '0;
         info_en <= 1'b0;
      end else if (step) begin
         {page, row, col} <= flat_nx;
      end else begin
         if (col_wr)  col <= col_in;
         if (row_wr)  row <= row_in;
         if (page_wr) begin
            page    <= page_in;
            info_en <= info_in;
         end
      end
   end

   // R3: one step moves the flat address by exactly one, page bit 7 untouched
   p_step_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ({page, row, col} == $past(flat) + 1'b1));
   p_step_info_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> $stable(info_en));

endmodule

// File: rtl/flash_io_seq.sv
module flash_io_seq
   import flash_io_pkg::*;
#(
   parameter int MASS_CYC = 200,
   parameter int PAGE_CYC = 10,
   parameter int PROG_TMO = 40,
   parameter int NSLOT    = 3,
   parameter int SW       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [2:0]       cmd,
   input  logic             prog_write,
   input  logic [SW-1:0]    tgt_slot,
   input  logic             tgt_info,
   output logic             busy,
   output logic             erase_busy,
   output logic             prog_busy,
   output logic [2:0]       op_bits,
   output logic [NSLOT-1:0] erase_vec
);
   localparam int MAXC = (MASS_CYC > PAGE_CYC)
                       ? ((MASS_CYC > PROG_TMO) ? MASS_CYC : PROG_TMO)
                       : ((PAGE_CYC > PROG_TMO) ? PAGE_CYC : PROG_TMO);
   localparam int CW = $clog2(MAXC + 1);

   op_e           op;
   logic [CW-1:0] cnt;
   logic [SW-1:0] lat_slot;
   logic          lat_info;
   logic          fire;

   assign erase_busy = (op == OP_MASS) || (op == OP_PAGE);
   assign prog_busy  = (op == OP_PROG);
   assign busy       = (op != OP_IDLE);
   assign fire       = erase_busy && (cnt == '0);
   assign op_bits    = {op == OP_PROG, op == OP_PAGE, op == OP_MASS};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op       <= OP_IDLE;
         cnt      <= '0;
         lat_slot <= '0;
         lat_info <= 1'b0;
      end else begin
         unique case (op)
            OP_IDLE: if (cmd_wr) begin
               lat_slot <= tgt_slot;
               lat_info <= tgt_info;
               if (cmd[CMD_MASS]) begin
                  op  <= OP_MASS;
                  cnt <= CW'(MASS_CYC - 1);
               end else if (cmd[CMD_PAGE]) begin
                  op  <= OP_PAGE;
                  cnt <= CW'(PAGE_CYC - 1);
               end else if (cmd[CMD_PROG]) begin
                  op  <= OP_PROG;
                  cnt <= CW'(PROG_TMO - 1);
               end
            end
            OP_MASS, OP_PAGE: begin
               if (cnt == '0) op <= OP_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            OP_PROG: begin
               if (cmd_wr && !cmd[CMD_PROG]) op  <= OP_IDLE;
               else if (prog_write)          cnt <= CW'(PROG_TMO - 1);
               else if (cnt == '0)           op  <= OP_IDLE;
               else                          cnt <= cnt - 1'b1;
            end
            default: op <= OP_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_erase
      if (g == NSLOT - 1) begin : g_info
         assign erase_vec[g] = fire && (((op == OP_MASS) && lat_info) ||
                               ((op == OP_PAGE) && (lat_slot == SW'(g))));
      end else begin : g_main
         assign erase_vec[g] = fire && ((op == OP_MASS) ||
                               ((op == OP_PAGE) && (lat_slot == SW'(g))));
      end
   end

   // independent elapsed-cycle counter used only by the checks below
   logic [CW-1:0] elapsed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          elapsed <= '0;
      else if (erase_busy) elapsed <= elapsed + 1'b1;
      else                 elapsed <= '0;
   end

   p_page_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PAGE && cnt == '0) |-> (elapsed == CW'(PAGE_CYC - 1)));
   p_mass_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MASS && cnt == '0) |-> (elapsed == CW'(MASS_CYC - 1)));
   p_busy_cmd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_busy && cnt != '0 && cmd_wr) |=> (op == $past(op)));
   p_prog_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && cnt == '0 && !prog_write && !cmd_wr) |=> !busy);
   p_erase_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_vec != '0) |=> !erase_busy);

endmodule

// File: rtl/flash_io_array.sv
module flash_io_array #(
   parameter int ROW_W = 1,
   parameter int NSLOT = 3,
   parameter int SW    = 2
) (
   input  logic               clk,
   input  logic [NSLOT-1:0]   erase,
   input  logic               wr_en,
   input  logic [SW-1:0]      wr_slot,
   input  logic [ROW_W+7:0]   wr_off,
   input  logic [7:0]         wr_data,
   input  logic [SW-1:0]      slot_a,
   input  logic [ROW_W+7:0]   off_a,
   output logic [7:0]         rd_a,
   input  logic [SW-1:0]      slot_b,
   input  logic [ROW_W+7:0]   off_b,
   output logic [7:0]         rd_b
);
   localparam int OW = ROW_W + 8;
   localparam int PB = 1 << OW;

   logic [7:0] rd_a_s [NSLOT];
   logic [7:0] rd_b_s [NSLOT];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [7:0] mem [PB];
      always_ff @(posedge clk) begin
         if (erase[g]) begin
            for (int i = 0; i < PB; i++) mem[i] <= 8'hFF;
         end else if (wr_en && wr_slot == SW'(g)) begin
            mem[wr_off] <= mem[wr_off] & wr_data;
         end
      end
      assign rd_a_s[g] = mem[off_a];
      assign rd_b_s[g] = mem[off_b];
   end

   always_comb begin
      rd_a = 8'hFF;
      rd_b = 8'hFF;
      for (int s = 0; s < NSLOT; s++) begin
         if (slot_a == SW'(s)) rd_a = rd_a_s[s];
         if (slot_b == SW'(s)) rd_b = rd_b_s[s];
      end
   end

   // R5: programming and erasing never hit the array in the same cycle
   p_no_prog_erase_mix_r5: assert property (@(posedge clk)
      !(wr_en && (erase != '0)));

endmodule

// File: rtl/flash_io_ctrl.sv
module flash_io_ctrl
   import flash_io_pkg::*;
#(
   parameter int ROW_W    = 1,
   parameter int PAGE_W   = 1,
   parameter int CLK_KHZ  = 1,
   parameter int MASS_MS  = 200,
   parameter int PAGE_MS  = 10,
   parameter int PROG_TMO = 40
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0]                reg_sel,
   input  logic                      reg_wr,
   input  logic                      reg_rd,
   input  logic [7:0]                reg_wdata,
   output logic [7:0]                reg_rdata,
   input  logic                      cpu_req,
   input  logic                      cpu_is_flash,
   input  logic                      cpu_we,
   input  logic [PAGE_W+ROW_W+7:0]   cpu_addr,
   output logic [7:0]                cpu_rdata,
   output logic                      stall
);
   localparam int NPAGE    = 1 << PAGE_W;
   localparam int NSLOT    = NPAGE + 1;
   localparam int SW       = $clog2(NSLOT);
   localparam int OW       = ROW_W + 8;
   localparam int AW       = PAGE_W + OW;
   localparam int MASS_CYC = CLK_KHZ * MASS_MS;
   localparam int PAGE_CYC = CLK_KHZ * PAGE_MS;

   if (ROW_W < 1 || ROW_W > 8) begin : g_bad_row
      $error("ROW_W must be 1..8");
   end
   if (PAGE_W < 1 || PAGE_W > 6) begin : g_bad_page
      $error("PAGE_W must be 1..6");
   end
   if (MASS_CYC < 2 || PAGE_CYC < 2 || PROG_TMO < 2) begin : g_bad_time
      $error("operation lengths must be at least 2 cycles");
   end

   logic [7:0]        col;
   logic [ROW_W-1:0]  row;
   logic [PAGE_W-1:0] page;
   logic              info_en;
   logic              busy, erase_busy, prog_busy;
   logic [2:0]        op_bits;
   logic [NSLOT-1:0]  erase_vec;
   logic              sel_data, dp_acc, cpu_flash, step, prog_write;
   logic [SW-1:0]     cur_slot, cpu_slot;
   logic [7:0]        dp_rdata;

   assign sel_data  = (reg_sel == SEL_DATA);
   assign dp_acc    = (reg_wr || reg_rd) && sel_data;
   assign cpu_flash = cpu_req && cpu_is_flash;

   assign stall = (erase_busy && (dp_acc || cpu_flash)) ||
                  (prog_busy  && ((reg_rd && sel_data) || (cpu_flash && !cpu_we)));

   assign step       = dp_acc && !stall;
   assign prog_write = reg_wr && sel_data && prog_busy && !stall;

   assign cur_slot = info_en ? SW'(NPAGE) : SW'(page);
   assign cpu_slot = SW'(cpu_addr[AW-1 -: PAGE_W]);

   flash_io_addr #(.ROW_W(ROW_W), .PAGE_W(PAGE_W)) i_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .col_wr  (reg_wr && reg_sel == SEL_COL),
      .row_wr  (reg_wr && reg_sel == SEL_ROW),
      .page_wr (reg_wr && reg_sel == SEL_PAGE),
      .col_in  (reg_wdata),
      .row_in  (reg_wdata[ROW_W-1:0]),
      .page_in (reg_wdata[PAGE_W-1:0]),
      .info_in (reg_wdata[PG_INFO]),
      .step    (step),
      .col     (col),
      .row     (row),
      .page    (page),
      .info_en (info_en)
   );

   flash_io_seq #(
      .MASS_CYC (MASS_CYC),
      .PAGE_CYC (PAGE_CYC),
      .PROG_TMO (PROG_TMO),
      .NSLOT    (NSLOT),
      .SW       (SW)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (reg_wr && reg_sel == SEL_CTRL),
      .cmd        (reg_wdata[2:0]),
      .prog_write (prog_write),
      .tgt_slot   (cur_slot),
      .tgt_info   (info_en),
      .busy       (busy),
      .erase_busy (erase_busy),
      .prog_busy  (prog_busy),
      .op_bits    (op_bits),
      .erase_vec  (erase_vec)
   );

   flash_io_array #(.ROW_W(ROW_W), .NSLOT(NSLOT), .SW(SW)) i_array (
      .clk     (clk),
      .erase   (erase_vec),
      .wr_en   (prog_write),
      .wr_slot (cur_slot),
      .wr_off  ({row, col}),
      .wr_data (reg_wdata),
      .slot_a  (cur_slot),
      .off_a   ({row, col}),
      .rd_a    (dp_rdata),
      .slot_b  (cpu_slot),
      .off_b   (cpu_addr[OW-1:0]),
      .rd_b    (cpu_rdata)
   );

   always_comb begin
      reg_rdata = 8'h00;
      unique case (reg_sel)
         SEL_COL:  reg_rdata = col;
         SEL_ROW:  reg_rdata[ROW_W-1:0] = row;
         SEL_PAGE: begin
            reg_rdata[PAGE_W-1:0] = page;
            reg_rdata[PG_INFO]    = info_en;
         end
         SEL_DATA: reg_rdata = dp_rdata;
         SEL_CTRL: begin
            reg_rdata[2:0]      = op_bits;
            reg_rdata[CTL_BUSY] = busy;
         end
         default:  reg_rdata = 8'h00;
      endcase
   end

   // R8: a stalled data-port access leaves the address registers untouched
   p_stall_holds_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && dp_acc) |=> $stable({page, row, col, info_en}));
   // R8: nothing stalls while the sequencer is idle
   p_idle_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !stall);
   // R9: program-mode data writes are always accepted
   p_prog_write_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && reg_wr && sel_data) |-> !stall);
   // R7: a mass erase clears every main page in the same cycle
   p_mass_all_pages_r7: assert property (@(posedge clk) disable iff (!rst_n)
      erase_vec[0] && op_bits[0] |-> (erase_vec[NPAGE-1:0] == '1));

endmodule

// File: tb/test_flash_io_ctrl.sv
module test_flash_io_ctrl;
   localparam int ROW_W = 1, PAGE_W = 1, AW = PAGE_W + ROW_W + 8;
   localparam int PB = 512, NROW = 2, NPAGE = 2;
   localparam int MASS = 200, PAGEC = 10, TMO = 40;

   logic          clk = 0, rst_n = 0;
   logic [2:0]    reg_sel = 0;
   logic          reg_wr = 0, reg_rd = 0;
   logic [7:0]    reg_wdata = 0, reg_rdata;
   logic          cpu_req = 0, cpu_is_flash = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = 0;
   logic [7:0]    cpu_rdata;
   logic          stall;

   flash_io_ctrl #(.ROW_W(ROW_W), .PAGE_W(PAGE_W), .CLK_KHZ(1), .MASS_MS(200),
                   .PAGE_MS(10), .PROG_TMO(TMO)) i_flash_io_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
      .cpu_is_flash(cpu_is_flash), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_rdata(cpu_rdata), .stall(stall));

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [7:0] refm [0:3*PB-1];
   int b_pg = 0, b_row = 0, b_col = 0, b_info = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   function automatic int idx();
      return (b_info != 0 ? NPAGE : b_pg) * PB + b_row * 256 + b_col;
   endfunction

   task automatic adv();
      b_col++;
      if (b_col == 256) begin b_col = 0; b_row++; end
      if (b_row == NROW) begin b_row = 0; b_pg = (b_pg + 1) % NPAGE; end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [7:0] d);
      @(negedge clk); reg_sel = s; reg_rd = 1;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 0;
   endtask

   task automatic set_addr(int pg, int row, int col, int info);
      wr(3'd2, 8'(pg) | (info != 0 ? 8'h80 : 8'h00));
      wr(3'd1, 8'(row));
      wr(3'd0, 8'(col));
      b_pg = pg; b_row = row; b_col = col; b_info = info;
   endtask

   task automatic cpu_rd(int a, output logic [7:0] d);
      @(negedge clk); cpu_req = 1; cpu_is_flash = 1; cpu_we = 0; cpu_addr = AW'(a);
      #1 d = cpu_rdata;
      @(negedge clk); cpu_req = 0;
   endtask

   // starts at the current negedge; one cycle per probe
   task automatic probe(bit cpu, bit flash, bit dp_rd, output logic s);
      cpu_req = cpu; cpu_is_flash = flash; cpu_we = 0;
      reg_sel = 3'd3; reg_rd = dp_rd;
      #1 s = stall;
      @(negedge clk); cpu_req = 0; reg_rd = 0;
   endtask

   // counts negedges, from the current one, on which control bit 7 reads 1
   task automatic busy_len(output int n, output logic [7:0] first);
      n = 0;
      reg_sel = 3'd4; reg_rd = 1;
      #1 first = reg_rdata;
      while (reg_rdata[7] && n < 1000) begin
         n++;
         @(negedge clk); #1;
      end
      reg_rd = 0;
   endtask

   initial begin
      #(20 * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      logic [7:0] v, first;
      logic s;
      int n, a, seed;
      seed = $urandom(32'd4242);

      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(3'd0, v); chk("R1 col", v, 0);
      rd(3'd1, v); chk("R1 row", v, 0);
      rd(3'd2, v); chk("R1 page", v, 0);
      rd(3'd4, v); chk("R1 ctrl", v, 0);
      chk("R1 stall", stall, 0);

      // R7/R8 mass erase including info page, with stall probes
      wr(3'd2, 8'h80);
      wr(3'd4, 8'h01);
      probe(1, 1, 0, s); chk("R8 cpu flash stalls", s, 1);
      probe(1, 0, 0, s); chk("R8 non-flash free", s, 0);
      probe(0, 0, 1, s); chk("R8 data port stalls", s, 1);
      busy_len(n, first);
      chk("R7 ctrl during mass", first, 8'h81);
      chk("R7 mass length", n + 3, MASS);
      rd(3'd0, v); chk("R8 addr held", v, 0);
      for (int i = 0; i < 3 * PB; i++) refm[i] = 8'hFF;
      for (int i = 0; i < 8; i++) begin
         a = int'($urandom % (NPAGE * PB));
         cpu_rd(a, v); chk("R7 main erased", v, 8'hFF);
      end
      set_addr(0, 0, 0, 1);
      for (int i = 0; i < 4; i++) begin
         rd(3'd3, v); chk("R7 info erased", v, refm[idx()]); adv();
      end

      // R2 register widths
      wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2 col", v, 8'hA5);
      wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 row", v, 8'h01);
      wr(3'd2, 8'hFF); rd(3'd2, v); chk("R2 page", v, 8'h81);
      wr(3'd2, 8'h00); rd(3'd2, v); chk("R2 page clear", v, 8'h00);

      // R5/R9 program across row and page boundaries
      set_addr(0, 0, 0, 0);
      wr(3'd4, 8'h04);
      rd(3'd4, v); chk("R11 ctrl busy prog", v, 8'h84);
      probe(1, 1, 0, s); chk("R9 cpu read stalls", s, 1);
      probe(0, 0, 1, s); chk("R9 dp read stalls", s, 1);
      for (int i = 0; i < 600; i++) begin
         v = 8'($urandom);
         @(negedge clk); reg_sel = 3'd3; reg_wdata = v; reg_wr = 1;
         #1 if (i == 0) chk("R9 dp write free", stall, 0);
         @(negedge clk); reg_wr = 0;
         refm[idx()] = refm[idx()] & v; adv();
      end
      wr(3'd4, 8'h00);
      rd(3'd4, v); chk("R10 sw end", v, 8'h00);
      rd(3'd0, v); chk("R3 col", v, b_col);
      rd(3'd1, v); chk("R3 row", v, b_row);
      rd(3'd2, v); chk("R3 page", v, b_pg);
      set_addr(0, 0, 0, 0);
      for (int i = 0; i < 600; i++) begin
         rd(3'd3, v); chk("R4 dp read", v, refm[idx()]); adv();
      end

      // R3 full wrap
      set_addr(1, 1, 255, 0);
      rd(3'd3, v);
      rd(3'd0, v); chk("R3 wrap col", v, 0);
      rd(3'd1, v); chk("R3 wrap row", v, 0);
      rd(3'd2, v); chk("R3 wrap page", v, 0);

      // R5 write without program mode
      set_addr(0, 0, 5, 0);
      wr(3'd3, 8'h00);
      rd(3'd0, v); chk("R5 addr step", v, 6);
      cpu_rd(5, v); chk("R5 unchanged", v, refm[5]);

      // R5/R10 AND programming then timeout
      wr(3'd4, 8'h04);
      set_addr(0, 0, 100, 0);
      for (int i = 0; i < 16; i++) begin
         v = 8'($urandom);
         wr(3'd3, v);
         refm[idx()] = refm[idx()] & v; adv();
      end
      busy_len(n, first);
      chk("R10 timeout", n, TMO);
      for (int i = 100; i < 116; i++) begin
         cpu_rd(i, v); chk("R5 and program", v, refm[i]);
      end

      // R6/R11 page erase of page 1 with a command during it
      wr(3'd2, 8'h01);
      wr(3'd4, 8'h02);
      wr(3'd4, 8'h01);
      busy_len(n, first);
      chk("R11 ignored cmd", first, 8'h82);
      chk("R6 page length", n + 2, PAGEC);
      for (int i = PB; i < 2 * PB; i++) refm[i] = 8'hFF;
      for (int i = 0; i < 12; i++) begin
         a = int'($urandom % (NPAGE * PB));
         cpu_rd(a, v); chk("R6 page erase result", v, refm[a]);
      end

      // R12/R7 priority, info page kept when enable clear
      set_addr(0, 0, 0, 1);
      wr(3'd4, 8'h04);
      for (int i = 0; i < 4; i++) begin
         v = 8'($urandom);
         wr(3'd3, v); refm[idx()] = refm[idx()] & v; adv();
      end
      wr(3'd4, 8'h00);
      wr(3'd2, 8'h00);
      wr(3'd4, 8'h07);
      busy_len(n, first);
      chk("R12 priority", first, 8'h81);
      chk("R7 mass length no info", n, MASS);
      for (int i = 0; i < NPAGE * PB; i++) refm[i] = 8'hFF;
      set_addr(0, 0, 0, 1);
      for (int i = 0; i < 4; i++) begin
         rd(3'd3, v); chk("R7 info kept", v, refm[idx()]); adv();
      end
      for (int i = 0; i < 6; i++) begin
         a = int'($urandom % (NPAGE * PB));
         cpu_rd(a, v); chk("R7 main cleared", v, 8'hFF);
      end

      report();
   end
endmodule